// File: doc/BRIEF.md
# Cascaded 32-bit Timer with Paired Input Capture

This block joins two 16-bit counting channels into one 32-bit count. The lower channel holds the low half. The upper channel holds the high half and, in cascade mode, advances only when the lower channel wraps. The lower channel counts up on a prescaled tick. It can also be put in an up/down stepping mode, in which it takes single step requests with a direction bit, such as those decoded from a quadrature encoder. The upper channel has its own stepping mode. Selecting that mode separates the two channels, whatever the cascade setting is.

Each channel has two capture registers, A and B, and each register watches a capture pin. Every capture has an enable bit that ORs in the same-letter pin of the other channel. With that bit set, one pin edge can latch both halves of the 32-bit count on the same clock. Edges are detected on the synchronised, ORed level. While one of the two pins is high, activity on the other pin does not register. Each capture can be set to respond to rising edges, falling edges or both.

Top module: `cascade_timer`

## Requirements
- R1: After reset both counters and all four capture registers read zero.
- R2: With the lower channel out of stepping mode, each cycle with `tick` and `lo_run` high increments `lo_cnt` by one. `lo_down` and `lo_step` have no effect in this mode.
- R3: In lower stepping mode (`lo_phase_mode`=1), a cycle with `lo_run` and `lo_step` high moves `lo_cnt` up by one when `lo_down`=0 and down by one when `lo_down`=1. Without a step the count holds.
- R4: In cascade mode (`cascade_en`=1, `hi_phase_mode`=0, `hi_run`=1), a lower step from 0xFFFF to 0x0000 increments `hi_cnt` on the same clock edge. A lower step from 0x0000 to 0xFFFF decrements `hi_cnt` on the same clock edge.
- R5: With `hi_phase_mode`=1, `hi_cnt` moves only on `hi_step` (up when `hi_down`=0, down when 1). Lower-channel wraps do not change it, even with `cascade_en`=1.
- R6: With `cascade_en`=0 and `hi_phase_mode`=0, `hi_cnt` increments on each cycle with `tick` and `hi_run` high. Lower-channel wraps do not affect it.
- R7: Capture index k uses bit k of `cap_pin`, `pair_en` and field `edge_sel[2k+1:2k]`, in the order 0 = upper A, 1 = upper B, 2 = lower A, 3 = lower B. Captures 0 and 1 load `hi_cnt`; captures 2 and 3 load `lo_cnt`. With `pair_en[k]`=0, only pin k can trigger capture k.
- R8: With `pair_en[k]`=1, capture k triggers on edges of pin k OR pin (k XOR 2). One edge on a shared pin therefore latches both counter halves on the same clock.
- R9: While either pin of an enabled pair is high, level changes on the other pin cause no capture.
- R10: Edge select encoding is 00 = rising, 01 = falling, 10 or 11 = both edges. A capture register changes only when its selected edge is seen.
- R11: Pins pass through a two-flop synchroniser. The counter value latched is the one held in the cycle after the synchronised level changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| cascade_en | input | 1 | 1: upper counts on lower wraps |
| lo_phase_mode | input | 1 | Lower channel in up/down stepping mode |
| lo_run | input | 1 | Lower channel enable |
| lo_step | input | 1 | Lower step request (stepping mode) |
| lo_down | input | 1 | Lower step direction, 1 = down |
| hi_phase_mode | input | 1 | Upper channel in stepping mode (forces independent) |
| hi_run | input | 1 | Upper channel enable |
| hi_step | input | 1 | Upper step request (stepping mode) |
| hi_down | input | 1 | Upper step direction, 1 = down |
| cap_pin | input | 4 | Capture pins, index order per R7 |
| pair_en | input | 4 | Per-capture partner-pin OR enable |
| edge_sel | input | 8 | Two-bit edge mode per capture |
| hi_cnt | output | 16 | Upper counter |
| lo_cnt | output | 16 | Lower counter |
| cap_hi_a | output | 16 | Upper channel capture A |
| cap_hi_b | output | 16 | Upper channel capture B |
| cap_lo_a | output | 16 | Lower channel capture A |
| cap_lo_b | output | 16 | Lower channel capture B |

## Verification
Assertions check on every cycle the following. Counting in free-running and stepping modes changes the counter by exactly one. A wrap leaves the lower half at the opposite extreme, and the upper half moves with it on the same edge. The upper half holds whenever its mode says it has no count source. While a pin of a pair stays high, no capture is taken, and a capture register holds unless an edge is seen. The bench scenarios show behaviour that only an end-to-end sequence can reveal. They check the upward wrap after a full sweep of 65536 ticks and the 16-bit crossing in both directions. They check that one shared pin edge latches both halves at once, that falling-only and both-edge selection work, and the synchroniser latency that decides which count value is latched.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
   localparam int NUM_CAP = 4;

   typedef enum logic [1:0] {
      EDGE_RISE  = 2'b00,
      EDGE_FALL  = 2'b01,
      EDGE_BOTH  = 2'b10,
      EDGE_BOTHX = 2'b11
   } edge_mode_e;

   // partner pin of capture k: same letter, other channel
   function automatic int mate_of(input int k);
      return k ^ 2;
   endfunction
endpackage

// File: rtl/ctmr_sync.sv
module ctmr_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ctmr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stage_q[s] <= '0;
            else if (s == 0)
               stage_q[s] <= d;
            else
               stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [WIDTH-1:0] cnt,
   output logic             wrap_up,
   output logic             wrap_dn
);
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
   localparam logic [WIDTH-1:0] TOPV = '1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("ctmr_counter: WIDTH must be at least 2");
      end
   endgenerate

   assign wrap_up = inc && (cnt == TOPV);
   assign wrap_dn = dec && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (inc)
         cnt <= cnt + ONE;
      else if (dec)
         cnt <= cnt - ONE;
   end

   // R3
   inc_dec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && dec));
   // R4
   wrap_up_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_up |=> (cnt == '0));
   // R4
   wrap_dn_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_dn |=> (cnt == TOPV));
endmodule

// File: rtl/ctmr_capture.sv
module ctmr_capture
   import ctmr_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             own_s,
   input  logic             mate_s,
   input  logic             pair,
   input  logic [1:0]       mode,
   input  logic [WIDTH-1:0] cnt,
   output logic [WIDTH-1:0] cap_q
);
   logic src, src_q, rise, fall, fire;

   assign src  = own_s | (pair & mate_s);
   assign rise = src & ~src_q;
   assign fall = ~src & src_q;

   always_comb begin
      unique case (edge_mode_e'(mode))
         EDGE_RISE: fire = rise;
         EDGE_FALL: fire = fall;
         default:   fire = rise | fall;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         cap_q <= '0;
      end else begin
         src_q <= src;
         if (fire)
            cap_q <= cnt;
      end
   end

   // R9
   masked_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pair && own_s && $past(own_s)) |-> !fire);
   // R9
   masked_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_s && $past(own_s)) |-> !fire);
   // R10
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(cap_q));
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
   import ctmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cascade_en,
   input  logic             lo_phase_mode,
   input  logic             lo_run,
   input  logic             lo_step,
   input  logic             lo_down,
   input  logic             hi_phase_mode,
   input  logic             hi_run,
   input  logic             hi_step,
   input  logic             hi_down,
   input  logic [3:0]       cap_pin,
   input  logic [3:0]       pair_en,
   input  logic [7:0]       edge_sel,
   output logic [CNT_W-1:0] hi_cnt,
   output logic [CNT_W-1:0] lo_cnt,
   output logic [CNT_W-1:0] cap_hi_a,
   output logic [CNT_W-1:0] cap_hi_b,
   output logic [CNT_W-1:0] cap_lo_a,
   output logic [CNT_W-1:0] cap_lo_b
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("cascade_timer: CNT_W must be at least 2");
      end
   endgenerate

   logic lo_inc, lo_dec, hi_inc, hi_dec;
   logic lo_wrap_up, lo_wrap_dn, hi_wrap_up, hi_wrap_dn;

   // lower channel count request
   always_comb begin
      if (lo_phase_mode) begin
         lo_inc = lo_run & lo_step & ~lo_down;
         lo_dec = lo_run & lo_step &  lo_down;
      end else begin
         lo_inc = lo_run & tick;
         lo_dec = 1'b0;
      end
   end

   // upper channel source: stepping, cascade, or own tick
   always_comb begin
      if (hi_phase_mode) begin
         hi_inc = hi_run & hi_step & ~hi_down;
         hi_dec = hi_run & hi_step &  hi_down;
      end else if (cascade_en) begin
         hi_inc = hi_run & lo_wrap_up;
         hi_dec = hi_run & lo_wrap_dn;
      end else begin
         hi_inc = hi_run & tick;
         hi_dec = 1'b0;
      end
   end

   ctmr_counter #(.WIDTH(CNT_W)) u_lo_ctr (
      .clk(clk), .rst_n(rst_n), .inc(lo_inc), .dec(lo_dec),
      .cnt(lo_cnt), .wrap_up(lo_wrap_up), .wrap_dn(lo_wrap_dn)
   );

   ctmr_counter #(.WIDTH(CNT_W)) u_hi_ctr (
      .clk(clk), .rst_n(rst_n), .inc(hi_inc), .dec(hi_dec),
      .cnt(hi_cnt), .wrap_up(hi_wrap_up), .wrap_dn(hi_wrap_dn)
   );

   // capture pins synchronised before any ORing
   logic [3:0] pin_s;

   ctmr_sync #(.WIDTH(NUM_CAP), .STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(cap_pin), .q(pin_s)
   );

   logic [CNT_W-1:0] cap_val [NUM_CAP];

   genvar k;
   generate
      for (k = 0; k < NUM_CAP; k++) begin : g_cap
         localparam int MATE = mate_of(k);
         logic [CNT_W-1:0] src_cnt;
         if (k < 2) begin : g_upper
            assign src_cnt = hi_cnt;
         end else begin : g_lower
            assign src_cnt = lo_cnt;
         end
         ctmr_capture #(.WIDTH(CNT_W)) u_cap (
            .clk(clk), .rst_n(rst_n),
            .own_s(pin_s[k]), .mate_s(pin_s[MATE]),
            .pair(pair_en[k]), .mode(edge_sel[2*k +: 2]),
            .cnt(src_cnt), .cap_q(cap_val[k])
         );
      end
   endgenerate

   assign cap_hi_a = cap_val[0];
   assign cap_hi_b = cap_val[1];
   assign cap_lo_a = cap_val[2];
   assign cap_lo_b = cap_val[3];

   // R2
   lo_free_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_run && !lo_phase_mode && tick) |=> (lo_cnt == $past(lo_cnt) + ONE));
   // R3
   lo_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_phase_mode && !lo_step) |=> $stable(lo_cnt));
   // R4
   cascade_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade_en && !hi_phase_mode && hi_run && lo_run && !lo_phase_mode && tick
       && lo_cnt == '1) |=> (hi_cnt == $past(hi_cnt) + ONE && lo_cnt == '0));
   // R4
   cascade_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cascade_en && !hi_phase_mode && hi_run && lo_run && lo_phase_mode
       && lo_step && lo_down && lo_cnt == '0)
      |=> (hi_cnt == $past(hi_cnt) - ONE && lo_cnt == '1));
   // R5
   hi_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_phase_mode && !hi_step) |=> $stable(hi_cnt));
   // R6
   hi_indep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cascade_en && !hi_phase_mode && !(hi_run && tick)) |=> $stable(hi_cnt));
endmodule

// File: tb/cascade_timer_bench.sv
module cascade_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick, cascade_en, lo_phase_mode, lo_run, lo_step, lo_down;
   logic        hi_phase_mode, hi_run, hi_step, hi_down;
   logic [3:0]  cap_pin, pair_en;
   logic [7:0]  edge_sel;
   logic [15:0] hi_cnt, lo_cnt, cap_hi_a, cap_hi_b, cap_lo_a, cap_lo_b;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   cascade_timer u_cascade_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cascade_en(cascade_en),
      .lo_phase_mode(lo_phase_mode), .lo_run(lo_run), .lo_step(lo_step),
      .lo_down(lo_down), .hi_phase_mode(hi_phase_mode), .hi_run(hi_run),
      .hi_step(hi_step), .hi_down(hi_down), .cap_pin(cap_pin),
      .pair_en(pair_en), .edge_sel(edge_sel), .hi_cnt(hi_cnt),
      .lo_cnt(lo_cnt), .cap_hi_a(cap_hi_a), .cap_hi_b(cap_hi_b),
      .cap_lo_a(cap_lo_a), .cap_lo_b(cap_lo_b)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tick = 0; cascade_en = 1; lo_phase_mode = 0; lo_run = 1; lo_step = 0;
      lo_down = 0; hi_phase_mode = 0; hi_run = 1; hi_step = 0; hi_down = 0;
      cap_pin = 4'b0; pair_en = 4'b0; edge_sel = 8'h00;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic lo_pulse(input logic down);
      lo_step = 1'b1; lo_down = down;
      @(negedge clk);
      lo_step = 1'b0;
   endtask

   task automatic hi_pulse(input logic down);
      hi_step = 1'b1; hi_down = down;
      @(negedge clk);
      hi_step = 1'b0;
   endtask

   task automatic set_pin(input int idx, input logic v);
      cap_pin[idx] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk(hi_cnt, 16'h0, "R1 hi_cnt");
      chk(lo_cnt, 16'h0, "R1 lo_cnt");
      chk(cap_hi_a | cap_hi_b | cap_lo_a | cap_lo_b, 16'h0, "R1 captures");
   endtask

   task automatic t_step_boundary();
      do_reset();
      lo_phase_mode = 1;
      lo_pulse(1'b1);
      chk(lo_cnt, 16'hFFFF, "R4 underflow lo");
      chk(hi_cnt, 16'hFFFF, "R4 borrow hi");
      lo_pulse(1'b0);
      chk(lo_cnt, 16'h0000, "R4 overflow lo");
      chk(hi_cnt, 16'h0000, "R4 carry hi");
      lo_pulse(1'b0);
      repeat (3) @(negedge clk);
      chk(lo_cnt, 16'h0001, "R3 step up and hold");
      chk(hi_cnt, 16'h0000, "R3 no carry inside range");
   endtask

   task automatic t_free_wrap();
      do_reset();
      lo_down = 1;
      tick = 1;
      repeat (65535) @(negedge clk);
      chk(lo_cnt, 16'hFFFF, "R2 sweep to top");
      chk(hi_cnt, 16'h0000, "R2 no early carry");
      @(negedge clk);
      chk(lo_cnt, 16'h0000, "R4 free overflow lo");
      chk(hi_cnt, 16'h0001, "R4 free carry hi");
      repeat (5) @(negedge clk);
      tick = 0;
      chk(lo_cnt, 16'h0005, "R2 keeps counting up");
   endtask

   task automatic t_hi_phase();
      do_reset();
      lo_phase_mode = 1; hi_phase_mode = 1;
      lo_pulse(1'b1);
      chk(lo_cnt, 16'hFFFF, "R5 lower underflows");
      chk(hi_cnt, 16'h0000, "R5 cascade ignored");
      hi_pulse(1'b0); hi_pulse(1'b0); hi_pulse(1'b1);
      chk(hi_cnt, 16'h0001, "R5 upper steps");
   endtask

   task automatic t_indep();
      do_reset();
      cascade_en = 0; lo_phase_mode = 1; lo_run = 0;
      tick = 1;
      repeat (10) @(negedge clk);
      tick = 0;
      chk(hi_cnt, 16'd10, "R6 upper own tick");
      chk(lo_cnt, 16'd0, "R6 lower disabled");
      lo_run = 1;
      lo_pulse(1'b1);
      chk(lo_cnt, 16'hFFFF, "R6 lower wraps");
      chk(hi_cnt, 16'd10, "R6 wrap ignored by upper");
   endtask

   task automatic t_capture();
      do_reset();
      lo_phase_mode = 1;
      lo_pulse(1'b1); lo_pulse(1'b1);
      chk(lo_cnt, 16'hFFFE, "R3 two steps down");
      // own pin only
      set_pin(2, 1'b1);
      chk(cap_lo_a, 16'hFFFE, "R7 lower A own pin");
      chk(cap_hi_a, 16'h0000, "R7 upper A ignores partner");
      set_pin(2, 1'b0);
      // shared pin latches both halves
      pair_en[0] = 1'b1;
      lo_pulse(1'b0);
      set_pin(2, 1'b1);
      chk(cap_hi_a, 16'hFFFF, "R8 upper A via partner");
      chk(cap_lo_a, 16'hFFFF, "R8 lower A same edge");
      set_pin(2, 1'b0);
      // masking while one pin high
      pair_en[1] = 1'b1;
      set_pin(1, 1'b1);
      chk(cap_hi_b, 16'hFFFF, "R7 upper B own pin");
      lo_pulse(1'b0);
      chk(hi_cnt, 16'h0000, "R4 carry before mask test");
      set_pin(3, 1'b1);
      chk(cap_lo_b, 16'h0000, "R9 partner edge real");
      set_pin(3, 1'b0);
      chk(cap_hi_b, 16'hFFFF, "R9 masked by high pin");
      set_pin(1, 1'b0);
      chk(cap_hi_b, 16'hFFFF, "R10 falling ignored in rise mode");
      set_pin(1, 1'b1);
      chk(cap_hi_b, 16'h0000, "R9 unmasked rise");
      set_pin(1, 1'b0);
      // edge selection
      edge_sel[7:6] = 2'b01;
      edge_sel[5:4] = 2'b10;
      lo_pulse(1'b0);
      set_pin(3, 1'b1);
      chk(cap_lo_b, 16'h0000, "R10 rise ignored in fall mode");
      lo_pulse(1'b0);
      set_pin(3, 1'b0);
      chk(cap_lo_b, 16'h0002, "R10 fall captured");
      lo_pulse(1'b0);
      set_pin(2, 1'b1);
      chk(cap_lo_a, 16'h0003, "R10 both mode rise");
      chk(cap_hi_a, 16'h0000, "R8 partner rise upper A");
      lo_pulse(1'b0);
      set_pin(2, 1'b0);
      chk(cap_lo_a, 16'h0004, "R10 both mode fall");
   endtask

   task automatic t_latency();
      do_reset();
      lo_phase_mode = 1;
      // pin rises, then the count moves every cycle; the latched value shows the delay
      cap_pin[3] = 1'b1;
      lo_step = 1'b1; lo_down = 1'b0;
      repeat (6) @(negedge clk);
      lo_step = 1'b0;
      // pin sampled at edge 1, sync out after edge 2, loaded at edge 3 with count 2
      chk(cap_lo_b, 16'h0002, "R11 synchroniser latency");
   endtask

   initial begin
      rst_n = 1'b0;
      t_reset();
      t_step_boundary();
      t_free_wrap();
      t_hi_phase();
      t_indep();
      t_capture();
      t_latency();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule